// File: doc/BRIEF.md
# Separable Three-Tap Blur Pipeline

This block smooths a tile of 16-bit unsigned pixels that arrives in raster order, one pixel per transfer. The tile width is a parameter and the tile height is open-ended. One blur pass has two steps. First, each pixel is averaged with its left and right neighbours. Then three vertically adjacent horizontal results are averaged, using two rows of line storage. The pass is applied `ITERS` times (two by default) by chaining identical pass stages, so the second pass consumes the first pass's output stream directly.

Every accepted input pixel produces exactly one output pixel, at a fixed distance behind it in the stream. A quality flag travels with each output. It is high only when the whole window of every pass lay inside the current tile. Outputs near a border are still emitted, but with the flag low, and their data is meaningless. A start-of-tile pulse marks the first pixel of each tile. Positions in the last rows of a tile are pushed out by the pixels that follow, typically the next tile. Holding back the output stream stalls the whole pipeline.

Top module: `sep_blur_pipe`

## Requirements
- R1: After reset `outVld` is 0 and `inRdy` is 1. Outputs produced before the first position of the first tile reach the output carry `outGood` = 0.
- R2: One pass computes h(x,y) = floor((p(x-1,y)+p(x,y)+p(x+1,y))/3) and then v(x,y) = floor((h(x,y-1)+h(x,y)+h(x,y+1))/3). With two passes, every output with `outGood` = 1 equals the second pass's v, computed on the first pass's v.
- R3: The three-term sums are formed 18 bits wide, so a tile of all 0xFFFF produces 0xFFFF at every good position.
- R4: With W = `ROW_LEN` and a tile of H rows (x = column, y = row, both from 0), `outGood` is 1 exactly when 2 <= x <= W-3 and 2 <= y <= H-3, for the default two passes.
- R5: The k-th output transfer (k from 0) belongs to the stream position k - (ITERS*(W+2) + ITERS - 1), which is k - (2W+5) for two passes. Positions are counted over all accepted pixels, across tile boundaries.
- R6: While `outVld` is 1 and `outRdy` is 0, `outVld`, `outPix` and `outGood` hold their values. Over a run, the number of output transfers equals the number of accepted inputs, with none lost and none repeated.
- R7: While an output is pending and `outRdy` is 0, `inRdy` is 0.
- R8: `inSof` with the first pixel of a tile resets the column and row count. Results in a tile depend only on that tile's pixels, even when the line storage still holds data from the previous tile.
- R9: A cycle with `inVld` = 0 produces no output: if the pending output is taken during such a cycle, `outVld` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | Input pixel present |
| inRdy | output | 1 | Pipeline can take the input pixel |
| inPix | input | 16 | Input pixel value |
| inSof | input | 1 | Marks the first pixel of a tile; sampled with `inVld` |
| outVld | output | 1 | Output pixel present |
| outRdy | input | 1 | Consumer takes the output pixel |
| outPix | output | 16 | Blurred pixel value |
| outGood | output | 1 | Window of every pass lay inside the tile |

## Verification
The line storage is addressed by a free-running pointer that wraps every W accepted pixels. A pointer or column-tag fault therefore moves the vertical window. Good outputs then differ in value from the arithmetic reference within one row of the fault, and a shifted `outGood` pattern shows up at the next tile border. A wrong row tag or stale storage flag marks the first two rows of the following tile as good, so the tile that follows a saturated tile exposes such a fault in its first good row. A handshake fault changes the output count, or changes data while the output is stalled, at the very next stalled cycle.

// File: rtl/sep_blur_pkg.sv
package sep_blur_pkg;

  localparam int PIX_W = 16;
  localparam int SUM_W = PIX_W + 2;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [SUM_W-1:0] sum_t;
  // saturating row count: 0, 1, 2, 3 (3 means three or more)
  typedef logic [1:0] rowTag_t;

  typedef struct packed {
    logic    adv;  // one pixel accepted: every stage shifts
    rowTag_t row;  // row tag of the accepted pixel
  } strobe_t;

  function automatic pix_t avg3(pix_t a, pix_t b, pix_t c);
    sum_t s;
    sum_t q;
    s = sum_t'(a) + sum_t'(b) + sum_t'(c);
    q = s / sum_t'(3);
    return q[PIX_W-1:0];
  endfunction

  function automatic rowTag_t rowUp(rowTag_t r);
    return (r == 2'd3) ? 2'd3 : r + 2'd1;
  endfunction

  function automatic rowTag_t rowDown(rowTag_t r);
    return (r == 2'd0) ? 2'd0 : r - 2'd1;
  endfunction

endpackage

// File: rtl/sep_blur_stage.sv
module sep_blur_stage
  import sep_blur_pkg::*;
#(
  parameter int ROW_LEN = 2000,
  parameter int COL_W   = $clog2(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adv,
  input  pix_t             inPix,
  input  logic             inGood,
  input  logic [COL_W-1:0] inCol,
  input  rowTag_t          inRow,
  output pix_t             outPix,
  output logic             outGood,
  output logic [COL_W-1:0] outCol,
  output rowTag_t          outRow
);

  localparam logic [COL_W-1:0] PTR_LAST = COL_W'(ROW_LEN - 1);

  // horizontal taps: mid = previous pixel, old = the one before
  pix_t             midPix, oldPix;
  logic             midGood, oldGood;
  logic [COL_W-1:0] midCol, oldCol;
  rowTag_t          midRow;

  // horizontal result register
  pix_t             hPix;
  logic             hGood;
  logic [COL_W-1:0] hCol;
  rowTag_t          hRow;

  // line storage: near = one row up, far = two rows up
  pix_t             lbNear  [ROW_LEN];
  pix_t             lbFar   [ROW_LEN];
  logic             lbNearG [ROW_LEN];
  logic             lbFarG  [ROW_LEN];
  logic [COL_W-1:0] ptr;

  pix_t hNew;
  logic hGoodNew;
  pix_t nearPix, farPix;
  logic nearGood, farGood;

  always_comb begin
    hNew     = avg3(inPix, midPix, oldPix);
    hGoodNew = inGood && midGood && oldGood &&
               (({1'b0, midCol} + 1'b1) == {1'b0, inCol}) &&
               (({1'b0, oldCol} + 1'b1) == {1'b0, midCol});
    nearPix  = lbNear[ptr];
    farPix   = lbFar[ptr];
    nearGood = lbNearG[ptr];
    farGood  = lbFarG[ptr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      midPix  <= '0;
      oldPix  <= '0;
      midGood <= 1'b0;
      oldGood <= 1'b0;
      midCol  <= '0;
      oldCol  <= '0;
      midRow  <= '0;
      hPix    <= '0;
      hGood   <= 1'b0;
      hCol    <= '0;
      hRow    <= '0;
      ptr     <= '0;
      outPix  <= '0;
      outGood <= 1'b0;
      outCol  <= '0;
      outRow  <= '0;
    end else if (adv) begin
      midPix  <= inPix;
      oldPix  <= midPix;
      midGood <= inGood;
      oldGood <= midGood;
      midCol  <= inCol;
      oldCol  <= midCol;
      midRow  <= inRow;
      hPix    <= hNew;
      hGood   <= hGoodNew;
      hCol    <= midCol;
      hRow    <= midRow;
      ptr     <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      outPix  <= avg3(farPix, nearPix, hPix);
      outGood <= hGood && nearGood && farGood && (hRow >= 2'd2);
      outCol  <= hCol;
      outRow  <= rowDown(hRow);
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      lbNear[ptr]  <= hPix;
      lbNearG[ptr] <= hGood;
      lbFar[ptr]   <= nearPix;
      lbFarG[ptr]  <= nearGood;
    end
  end

  // checker-side bounds of the horizontal window
  pix_t loV, hiV;
  always_comb begin
    loV = inPix;
    hiV = inPix;
    if (midPix < loV) loV = midPix;
    if (oldPix < loV) loV = oldPix;
    if (midPix > hiV) hiV = midPix;
    if (oldPix > hiV) hiV = oldPix;
  end

  // R2
  avg_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    adv |-> (hNew >= loV && hNew <= hiV));

  // R4
  good_col_interior_chk: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> (int'(outCol) >= 1 && int'(outCol) <= ROW_LEN - 2));

  // R8
  good_row_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> (outRow != 2'd0));

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) < ROW_LEN);

endmodule

// File: rtl/sep_blur_ctrl.sv
module sep_blur_ctrl
  import sep_blur_pkg::*;
#(
  parameter int ROW_LEN = 2000,
  parameter int COL_W   = $clog2(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inVld,
  input  logic             inSof,
  input  logic             outRdy,
  output logic             inRdy,
  output logic             outVld,
  output strobe_t          stb,
  output logic [COL_W-1:0] curCol
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_LEN - 1);

  logic             outVldQ;
  logic [COL_W-1:0] colCnt;
  rowTag_t          rowCnt;
  rowTag_t          curRow;
  logic             adv;

  always_comb begin
    inRdy   = !outVldQ || outRdy;
    adv     = inVld && inRdy;
    curCol  = inSof ? '0 : colCnt;
    curRow  = inSof ? '0 : rowCnt;
    stb.adv = adv;
    stb.row = curRow;
    outVld  = outVldQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVldQ <= 1'b0;
      colCnt  <= '0;
      rowCnt  <= '0;
    end else begin
      if (adv) begin
        outVldQ <= 1'b1;
        colCnt  <= (curCol == COL_LAST) ? '0 : curCol + 1'b1;
        rowCnt  <= (curCol == COL_LAST) ? rowUp(curRow) : curRow;
      end else if (outRdy) begin
        outVldQ <= 1'b0;
      end
    end
  end

  // R7
  stall_freezes_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVldQ && !outRdy) |=> ($stable(colCnt) && $stable(rowCnt)));

  // R9
  bubble_drains_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVldQ && outRdy && !inVld) |=> !outVldQ);

  // R8
  col_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(colCnt) < ROW_LEN);

endmodule

// File: rtl/sep_blur_dp.sv
module sep_blur_dp
  import sep_blur_pkg::*;
#(
  parameter int ROW_LEN = 2000,
  parameter int ITERS   = 2,
  parameter int COL_W   = $clog2(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  pix_t             inPix,
  input  logic [COL_W-1:0] inCol,
  output pix_t             outPix,
  output logic             outGood
);

  pix_t             lnkPix  [ITERS+1];
  logic             lnkGood [ITERS+1];
  logic [COL_W-1:0] lnkCol  [ITERS+1];
  rowTag_t          lnkRow  [ITERS+1];

  assign lnkPix[0]  = inPix;
  assign lnkGood[0] = 1'b1;
  assign lnkCol[0]  = inCol;
  assign lnkRow[0]  = stb.row;

  for (genvar i = 0; i < ITERS; i++) begin : g_pass
    sep_blur_stage #(
      .ROW_LEN(ROW_LEN),
      .COL_W  (COL_W)
    ) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .adv    (stb.adv),
      .inPix  (lnkPix[i]),
      .inGood (lnkGood[i]),
      .inCol  (lnkCol[i]),
      .inRow  (lnkRow[i]),
      .outPix (lnkPix[i+1]),
      .outGood(lnkGood[i+1]),
      .outCol (lnkCol[i+1]),
      .outRow (lnkRow[i+1])
    );
  end

  assign outPix  = lnkPix[ITERS];
  assign outGood = lnkGood[ITERS];

  // R4
  final_col_interior_chk: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> (int'(lnkCol[ITERS]) >= ITERS &&
                 int'(lnkCol[ITERS]) <= ROW_LEN - 1 - ITERS));

  // R8
  final_row_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> (lnkRow[ITERS] != 2'd0));

endmodule

// File: rtl/sep_blur_pipe.sv
module sep_blur_pipe
  import sep_blur_pkg::*;
#(
  parameter int ROW_LEN = 2000,
  parameter int ITERS   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVld,
  output logic        inRdy,
  input  logic [15:0] inPix,
  input  logic        inSof,
  output logic        outVld,
  input  logic        outRdy,
  output logic [15:0] outPix,
  output logic        outGood
);

  localparam int COL_W = $clog2(ROW_LEN);

  strobe_t          stb;
  logic [COL_W-1:0] curCol;

  sep_blur_ctrl #(
    .ROW_LEN(ROW_LEN),
    .COL_W  (COL_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .inSof (inSof),
    .outRdy(outRdy),
    .inRdy (inRdy),
    .outVld(outVld),
    .stb   (stb),
    .curCol(curCol)
  );

  sep_blur_dp #(
    .ROW_LEN(ROW_LEN),
    .ITERS  (ITERS),
    .COL_W  (COL_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .inPix  (inPix),
    .inCol  (curCol),
    .outPix (outPix),
    .outGood(outGood)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && !outRdy) |=> (outVld && $stable(outPix) && $stable(outGood)));

endmodule

// File: tb/sep_blur_pipe_tb.sv
module sep_blur_pipe_tb;

  localparam int W     = 8;
  localparam int NT    = 4;
  localparam int MAXR  = 7;
  localparam int LAT   = 2 * W + 5;
  localparam int MAXP  = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVld = 1'b0;
  logic        inRdy;
  logic [15:0] inPix = '0;
  logic        inSof = 1'b0;
  logic        outVld;
  logic        outRdy = 1'b0;
  logic [15:0] outPix;
  logic        outGood;

  always #2 clk = ~clk;

  sep_blur_pipe #(.ROW_LEN(W), .ITERS(2)) u_dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy), .inPix(inPix),
    .inSof(inSof), .outVld(outVld), .outRdy(outRdy), .outPix(outPix),
    .outGood(outGood)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  int tp [NT][MAXR][W];
  int rows [NT] = '{6, 5, 7, 3};
  int glT [MAXP];
  int glX [MAXP];
  int glY [MAXP];
  int nAcc = 0;
  int nOut = 0;
  bit holdPend = 1'b0;
  logic [15:0] holdPix;
  logic holdGood;
  bit bubbleTaken = 1'b0;
  bit forceRdy = 1'b0;

  function automatic int unsigned nextRnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic int h1(int t, int x, int y);
    return (tp[t][y][x-1] + tp[t][y][x] + tp[t][y][x+1]) / 3;
  endfunction
  function automatic int v1(int t, int x, int y);
    return (h1(t, x, y-1) + h1(t, x, y) + h1(t, x, y+1)) / 3;
  endfunction
  function automatic int h2(int t, int x, int y);
    return (v1(t, x-1, y) + v1(t, x, y) + v1(t, x+1, y)) / 3;
  endfunction
  function automatic int v2(int t, int x, int y);
    return (h2(t, x, y-1) + h2(t, x, y) + h2(t, x, y+1)) / 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkOut();
    int p;
    int t;
    int x;
    int y;
    bit expGood;
    string tag;
    p = nOut - LAT;
    nOut++;
    if (p < 0) begin
      check(outGood == 1'b0, "R1 good before first position", int'(outGood), 0);
      return;
    end
    t = glT[p];
    x = glX[p];
    y = glY[p];
    expGood = (x >= 2) && (x <= W - 3) && (y >= 2) && (y <= rows[t] - 3);
    check(outGood == expGood, "R4 R5 good flag", int'(outGood), int'(expGood));
    if (expGood && outGood) begin
      tag = (t == 1) ? "R3 saturated value" : ((t == 2) ? "R8 value after tile change" : "R2 value");
      check(int'(outPix) == v2(t, x, y), tag, int'(outPix), v2(t, x, y));
    end
  endtask

  task automatic step(input bit havePix, input int pix, input bit sofB, output bit took);
    @(negedge clk);
    if (holdPend) begin
      check(outVld == 1'b1, "R6 valid held", int'(outVld), 1);
      check(outPix == holdPix && outGood == holdGood, "R6 data held", int'(outPix), int'(holdPix));
    end
    if (bubbleTaken)
      check(outVld == 1'b0, "R9 no output from bubble", int'(outVld), 0);
    outRdy = forceRdy ? 1'b1 : ((nextRnd() % 4) != 0);
    inVld  = havePix;
    inPix  = 16'(pix);
    inSof  = sofB;
    #1;
    if (outVld && !outRdy)
      check(inRdy == 1'b0, "R7 input blocked during stall", int'(inRdy), 0);
    took = inVld && inRdy;
    bubbleTaken = !inVld && outVld && outRdy;
    if (outVld && outRdy) checkOut();
    holdPend = outVld && !outRdy;
    holdPix  = outPix;
    holdGood = outGood;
  endtask

  initial begin
    bit took;
    for (int t = 0; t < NT; t++)
      for (int y = 0; y < MAXR; y++)
        for (int x = 0; x < W; x++) begin
          case (t)
            0: tp[t][y][x] = (x * 4099 + y * 7919 + 123) % 65536;
            1: tp[t][y][x] = 65535;
            2: tp[t][y][x] = int'(nextRnd() % 65536);
            default: tp[t][y][x] = 0;
          endcase
        end

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(outVld == 1'b0, "R1 outVld after reset", int'(outVld), 0);
    check(inRdy == 1'b1, "R1 inRdy after reset", int'(inRdy), 1);

    for (int t = 0; t < NT; t++)
      for (int y = 0; y < rows[t]; y++)
        for (int x = 0; x < W; x++) begin
          glT[nAcc] = t;
          glX[nAcc] = x;
          glY[nAcc] = y;
          took = 1'b0;
          while (!took) begin
            if ((nextRnd() % 5) == 0) step(1'b0, 0, 1'b0, took);
            else step(1'b1, tp[t][y][x], (x == 0) && (y == 0), took);
          end
          nAcc++;
        end

    forceRdy = 1'b1;
    for (int i = 0; i < 8 && nOut < nAcc; i++) step(1'b0, 0, 1'b0, took);
    check(nOut == nAcc, "R6 one output per accepted input", nOut, nAcc);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL R6 watchdog: actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule